// File: doc/BRIEF.md
# Multi-format synchronous serial port

This block is a full-duplex synchronous serial port. Each frame carries one word of 4 to 32 bits, most significant bit first. Words to send wait in a TX FIFO, and words that arrive are stored in an RX FIFO. A single control word sets the word length, the frame style, the clock direction and the master clock divider, and it holds the enable. Two frame styles are built in:

- **SPI-style select:** the frame line is active low for the whole word.
- **TI-style pulse:** the frame line goes high for one bit period just before the first data bit.

As clock master, the port makes its serial clock from its own clock. The divide ratio runs from 1 to 4096. As clock slave, it takes one bit on each rising edge of an external serial clock, which it synchronises internally.

Software loads the configuration while the port is disabled, or in the same write that enables it. While the port is enabled, a control write can only clear the enable. Clearing the enable stops the frame in progress at once and empties both FIFOs. It also clears the status, but the configuration is kept.

Top module: `sspx_core`

## Requirements
- R1: The control word (address 0) has these fields:
  - size in bits 3:0 and a size extension in bit 4, together a 5-bit code whose word length is code + 1;
  - format in bits 6:5;
  - clock slave in bit 7;
  - enable in bit 8;
  - divider in bits 20:9.

  Reading address 0 returns these fields, with all other bits zero. After reset every field is 0.
- R2: As master, each bit lasts exactly divider + 1 clock cycles. An SPI-style frame keeps the frame line low for exactly length × (divider + 1) cycles.
- R3: Only the low length bits of a TX word are sent, MSB first, and txd is 0 outside the data bits. A received word is right-aligned in rx_data with zero upper bits.
- R4: In format 00 (SPI-style) the frame line idles high and is low exactly while data bits are in progress.
- R5: In format 01 (TI-style) the frame line idles low. It is high for exactly one bit period before the MSB, with txd at 0, and low during the data.
- R6: As clock slave (bit 7 = 1), one bit is taken on each rising edge of sclk_i, the divider is ignored and sclk_o stays low.
- R7: A frame starts only when the port is enabled, the TX FIFO holds a word and no frame is in progress. The port stays idle in these cases:
  - a size code below 3 (fewer than 4 bits);
  - format 10;
  - format 11.
- R8: While enable is 1, a control write changes only the enable bit; every other field keeps its value.
- R9: A control write that clears enable stops the frame at once: at that clock edge busy falls, the SPI-style frame line returns high, both FIFOs are emptied and the overrun flag clears. The other control fields are kept.
- R10: The status word (address 1) has these bits:
  - bit 0: TX not full;
  - bit 1: RX not empty;
  - bit 2: busy;
  - bit 3: RX overrun.

  tx_ready is low while the TX FIFO is full, and rx_valid is high while the RX FIFO holds a word. Each received word enters the RX FIFO at the clock edge that samples its last bit.
- R11: A word that completes while the RX FIFO is full is dropped and sets the overrun flag. The flag stays set until enable is cleared.
- R12: As master, sclk_o is low for the first floor((divider + 1) / 2) cycles of each bit period and high for the rest. It is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe (address 0 only) |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_valid | input | 1 | TX word offered |
| tx_ready | output | 1 | TX FIFO can accept a word |
| tx_data | input | DATA_W | TX word |
| rx_valid | output | 1 | RX word available |
| rx_ready | input | 1 | Consume the RX word |
| rx_data | output | DATA_W | Oldest received word |
| sclk_o | output | 1 | Serial clock in master mode |
| sclk_i | input | 1 | External serial clock in slave mode |
| frm_o | output | 1 | Frame line |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The bench builds the port with a FIFO depth of 4 and the default 32-bit word and 12-bit divider. The shallow depth makes a full TX FIFO and an RX overrun reachable within a few short frames.

The bench sweeps every legal word length from 4 to 32 bits in both frame styles. It tries divide ratios from 1 to 8 and the extreme ratio 4096. At each of these points it predicts the serial bit stream, the frame-line timing, the clock waveform and the received word arithmetically.

Slave-mode frames are clocked by the bench itself with the divider set to its maximum. Further checks cover reserved sizes and formats, configuration writes made while enabled, and an abort in the middle of a frame.

// File: rtl/sspx_pkg.sv
package sspx_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_PRE  = 2'd1,
      FS_DATA = 2'd2
   } frame_st_e;

   localparam logic [1:0] FMT_SPI = 2'b00;
   localparam logic [1:0] FMT_TI  = 2'b01;

   localparam int CP_SIZE_LO = 0;
   localparam int CP_EXT     = 4;
   localparam int CP_FMT_LO  = 5;
   localparam int CP_SLAVE   = 7;
   localparam int CP_EN      = 8;
   localparam int CP_DIV_LO  = 9;

   localparam int CODE_W   = 5;
   localparam int MIN_CODE = 3;

   function automatic logic cfg_legal(input logic [CODE_W-1:0] code,
                                      input logic [1:0] fmt);
      return (code >= CODE_W'(MIN_CODE)) && ((fmt == FMT_SPI) || (fmt == FMT_TI));
   endfunction

endpackage

// File: rtl/sspx_fifo.sv
module sspx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("sspx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end

endmodule

// File: rtl/sspx_clkgen.sv
module sspx_clkgen #(
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             slave,
   input  logic [DIV_W-1:0] div,
   input  logic             sclk_i,
   input  logic             rxd,
   output logic             tick,
   output logic             rxd_s,
   output logic             sclk_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sspx_clkgen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sck_sy, rx_sy;
   logic                   sck_prev;
   logic [DIV_W-1:0]       cnt;
   logic [DIV_W:0]         half;
   logic                   m_tick, s_tick;

   // external clock and data travel through matched synchronisers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sy   <= '0;
         rx_sy    <= '0;
         sck_prev <= 1'b0;
      end else begin
         sck_sy   <= {sck_sy[SYNC_STAGES-2:0], sclk_i};
         rx_sy    <= {rx_sy[SYNC_STAGES-2:0], rxd};
         sck_prev <= sck_sy[SYNC_STAGES-1];
      end
   end

   // master divider restarts with each frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || slave)    cnt <= '0;
      else if (cnt == div)       cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

   assign half   = ({1'b0, div} + 1'b1) >> 1;
   assign m_tick = run && !slave && (cnt == div);
   assign s_tick = run && slave && sck_sy[SYNC_STAGES-1] && !sck_prev;
   assign tick   = m_tick || s_tick;
   assign rxd_s  = slave ? rx_sy[SYNC_STAGES-1] : rxd;
   assign sclk_o = run && !slave && ({1'b0, cnt} >= half);

endmodule

// File: rtl/sspx_frame.sv
module sspx_frame
   import sspx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic              fmt_ti,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              tick,
   input  logic              rxd_s,
   output logic              busy,
   output logic              frm_o,
   output logic              txd,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_word
);
   frame_st_e         st;
   logic [LEN_W-1:0]  bitc;
   logic [LEN_W-1:0]  align;
   logic [DATA_W-1:0] tx_sh, rx_sh;

   assign align   = LEN_W'(DATA_W - 1) - len_m1;
   assign busy    = (st != FS_IDLE);
   assign txd     = (st == FS_DATA) && tx_sh[DATA_W-1];
   assign frm_o   = fmt_ti ? (st == FS_PRE) : (st != FS_DATA);
   assign rx_push = (st == FS_DATA) && tick && (bitc == '0);
   assign rx_word = {rx_sh[DATA_W-2:0], rxd_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= FS_IDLE;
         bitc  <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (abort) begin
         st <= FS_IDLE;
      end else begin
         unique case (st)
            FS_IDLE: if (start) begin
               st    <= fmt_ti ? FS_PRE : FS_DATA;
               bitc  <= len_m1;
               tx_sh <= tx_word << align;
               rx_sh <= '0;
            end
            FS_PRE: if (tick) st <= FS_DATA;
            FS_DATA: if (tick) begin
               tx_sh <= tx_sh << 1;
               rx_sh <= {rx_sh[DATA_W-2:0], rxd_s};
               if (bitc == '0) st <= FS_IDLE;
               else            bitc <= bitc - 1'b1;
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sspx_core.sv
module sspx_core
   import sspx_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int FIFO_DEPTH  = 16,
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              sclk_o,
   input  logic              sclk_i,
   output logic              frm_o,
   output logic              txd,
   input  logic              rxd
);
   localparam int LEN_W = $clog2(DATA_W);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("sspx_core: the 5-bit size code needs DATA_W of 32");
      end
      if (DIV_W < 1 || CP_DIV_LO + DIV_W > 32) begin : g_bad_div
         $error("sspx_core: DIV_W must fit the control word");
      end
   endgenerate

   logic [3:0]       size_q;
   logic             ext_q;
   logic [1:0]       fmt_q;
   logic             slave_q;
   logic             en_q;
   logic [DIV_W-1:0] div_q;
   logic             ovr_q;

   logic             wr_ctl, flush, start, cfg_ok, busy, tick, rxd_s;
   logic [LEN_W-1:0] len_m1;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic [DATA_W-1:0] tx_word, rx_word;
   logic             rx_push;
   logic [31:0]      ctl_word;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata[31:CP_DIV_LO+DIV_W-1];

   assign wr_ctl = reg_wr && !reg_addr;
   assign flush  = wr_ctl && en_q && !reg_wdata[CP_EN];
   assign len_m1 = {ext_q, size_q};
   assign cfg_ok = cfg_legal(len_m1, fmt_q);
   assign start  = en_q && cfg_ok && !tx_empty && !busy && !flush;

   // configuration is loaded only while disabled; enable always follows the write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q  <= '0;
         ext_q   <= 1'b0;
         fmt_q   <= FMT_SPI;
         slave_q <= 1'b0;
         en_q    <= 1'b0;
         div_q   <= '0;
      end else if (wr_ctl) begin
         if (!en_q) begin
            size_q  <= reg_wdata[CP_SIZE_LO +: 4];
            ext_q   <= reg_wdata[CP_EXT];
            fmt_q   <= reg_wdata[CP_FMT_LO +: 2];
            slave_q <= reg_wdata[CP_SLAVE];
            div_q   <= reg_wdata[CP_DIV_LO +: DIV_W];
         end
         en_q <= reg_wdata[CP_EN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovr_q <= 1'b0;
      else if (flush)             ovr_q <= 1'b0;
      else if (rx_push && rx_full) ovr_q <= 1'b1;
   end

   always_comb begin
      ctl_word                        = '0;
      ctl_word[CP_SIZE_LO +: 4]       = size_q;
      ctl_word[CP_EXT]                = ext_q;
      ctl_word[CP_FMT_LO +: 2]        = fmt_q;
      ctl_word[CP_SLAVE]              = slave_q;
      ctl_word[CP_EN]                 = en_q;
      ctl_word[CP_DIV_LO +: DIV_W]    = div_q;
   end

   assign reg_rdata = reg_addr ? {28'd0, ovr_q, busy, !rx_empty, !tx_full} : ctl_word;
   assign tx_ready  = !tx_full;
   assign rx_valid  = !rx_empty;

   sspx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (tx_valid),
      .wdata (tx_data),
      .pop   (start),
      .rdata (tx_word),
      .full  (tx_full),
      .empty (tx_empty)
   );

   sspx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (rx_push),
      .wdata (rx_word),
      .pop   (rx_ready),
      .rdata (rx_data),
      .full  (rx_full),
      .empty (rx_empty)
   );

   sspx_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .slave  (slave_q),
      .div    (div_q),
      .sclk_i (sclk_i),
      .rxd    (rxd),
      .tick   (tick),
      .rxd_s  (rxd_s),
      .sclk_o (sclk_o)
   );

   sspx_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_frm (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort   (flush),
      .start   (start),
      .fmt_ti  (fmt_q == FMT_TI),
      .len_m1  (len_m1),
      .tx_word (tx_word),
      .tick    (tick),
      .rxd_s   (rxd_s),
      .busy    (busy),
      .frm_o   (frm_o),
      .txd     (txd),
      .rx_push (rx_push),
      .rx_word (rx_word)
   );

endmodule

// File: rtl/sspx_core_chk.sv
module sspx_core_chk #(
   parameter int DIV_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             flush,
   input logic             busy,
   input logic             cfg_ok,
   input logic [1:0]       fmt_q,
   input logic [DIV_W-1:0] div_q,
   input logic             slave_q,
   input logic             sclk_o,
   input logic             frm_o,
   input logic             txd,
   input logic             ovr_q,
   input logic             rx_valid,
   input logic             tx_ready
);
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q)) |-> ($stable(div_q) && $stable(fmt_q) && $stable(slave_q)));

   a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!busy && !rx_valid && tx_ready && !ovr_q));

   a_r7_invalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q || !cfg_ok) |-> !busy);

   a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !flush) |=> ovr_q);

   a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      slave_q |-> !sclk_o);

   a_r4_select_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q == 2'b00 && !frm_o) |-> busy);

   a_r5_pulse_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q == 2'b01 && frm_o) |-> (busy && !txd));

   a_r12_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk_o);

endmodule

bind sspx_core sspx_core_chk #(.DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_q     (en_q),
   .flush    (flush),
   .busy     (busy),
   .cfg_ok   (cfg_ok),
   .fmt_q    (fmt_q),
   .div_q    (div_q),
   .slave_q  (slave_q),
   .sclk_o   (sclk_o),
   .frm_o    (frm_o),
   .txd      (txd),
   .ovr_q    (ovr_q),
   .rx_valid (rx_valid),
   .tx_ready (tx_ready)
);

// File: tb/sspx_core_tb.sv
module sspx_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [31:0] tx_data = '0;
   logic        rx_valid;
   logic        rx_ready = 1'b0;
   logic [31:0] rx_data;
   logic        sclk_o;
   logic        sclk_i = 1'b0;
   logic        frm_o;
   logic        txd;
   logic        rxd_b = 1'b0;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   sspx_core #(.DATA_W(32), .FIFO_DEPTH(4), .DIV_W(12), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .rx_data(rx_data), .sclk_o(sclk_o), .sclk_i(sclk_i),
      .frm_o(frm_o), .txd(txd), .rxd(rxd_b)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctl(input logic [4:0] code, input logic [1:0] fmt,
                                       input logic slv, input logic en, input int ratio);
      logic [11:0] d = 12'(ratio - 1);
      return {11'd0, d, en, slv, fmt, code};
   endfunction

   function automatic logic [31:0] lmask(input int len);
      logic [63:0] m = (64'd1 << len) - 64'd1;
      return m[31:0];
   endfunction

   task automatic wr_ctl(input logic [4:0] code, input logic [1:0] fmt, input logic slv,
                         input logic en, input int ratio);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = ctl(code, fmt, slv, en, ratio);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic push(input logic [31:0] w);
      @(negedge clk);
      tx_valid = 1'b1; tx_data = w;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic pop(output logic [31:0] w, output logic v);
      @(negedge clk);
      v = rx_valid; w = rx_data; rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
   endtask

   // watches one master frame already enabled; bench drives rxd, predicts everything
   task automatic observe(input logic [1:0] fmt, input int len, input int r,
                          input logic [31:0] txw, input logic [31:0] rxw);
      int t = 0; int pw = 0; int bad_frm = 0; int bad_clk = 0;
      logic [31:0] cap = '0; logic [31:0] got; logic v;
      logic want_frm = (fmt == 2'b01) ? 1'b1 : 1'b0;
      while (frm_o != want_frm && t < 1000) begin @(negedge clk); t++; end
      chk(t < 1000, "R7 frame start", 32'(t), 32'd0);
      if (fmt == 2'b01) begin
         while (frm_o == 1'b1 && pw < 9000) begin
            if (txd !== 1'b0) bad_frm++;
            @(negedge clk); pw++;
         end
         chk(pw == r, "R5 pulse width", 32'(pw), 32'(r));
      end
      for (int c = 0; c < len * r; c++) begin
         if (frm_o !== 1'b0) bad_frm++;
         if (sclk_o !== ((c % r) >= (r / 2))) bad_clk++;
         if ((c % r) == 0) cap = {cap[30:0], txd};
         rxd_b = rxw[len - 1 - c / r];
         @(negedge clk);
      end
      chk(bad_frm == 0, "R4 R5 frame line in data", 32'(bad_frm), 32'd0);
      chk(bad_clk == 0, "R12 sclk shape", 32'(bad_clk), 32'd0);
      chk(frm_o == (fmt == 2'b00), "R2 frame length", 32'(frm_o), 32'(fmt == 2'b00));
      chk(cap == (txw & lmask(len)), "R3 tx bits MSB first", cap, txw & lmask(len));
      pop(got, v);
      chk(v == 1'b1, "R10 rx word present", 32'(v), 32'd1);
      chk(got == (rxw & lmask(len)), "R3 rx word aligned", got, rxw & lmask(len));
   endtask

   task automatic mframe(input logic [1:0] fmt, input int len, input int r,
                         input logic [31:0] txw, input logic [31:0] rxw);
      wr_ctl(5'(len - 1), fmt, 1'b0, 1'b0, r);
      push(txw);
      wr_ctl(5'(len - 1), fmt, 1'b0, 1'b1, r);
      observe(fmt, len, r, txw, rxw);
      wr_ctl(5'(len - 1), fmt, 1'b0, 1'b0, r);
   endtask

   task automatic sframe(input int len, input logic [31:0] txw, input logic [31:0] rxw);
      logic [31:0] cap = '0; logic [31:0] got; logic v; int bad = 0;
      wr_ctl(5'(len - 1), 2'b00, 1'b1, 1'b0, 4096);
      push(txw);
      wr_ctl(5'(len - 1), 2'b00, 1'b1, 1'b1, 4096);
      repeat (3) @(negedge clk);
      chk(frm_o == 1'b0, "R6 slave frame started", 32'(frm_o), 32'd0);
      for (int i = 0; i < len; i++) begin
         sclk_i = 1'b0; rxd_b = rxw[len - 1 - i];
         repeat (4) begin @(negedge clk); if (sclk_o) bad++; end
         cap = {cap[30:0], txd};
         sclk_i = 1'b1;
         repeat (4) begin @(negedge clk); if (sclk_o) bad++; end
      end
      sclk_i = 1'b0;
      repeat (6) @(negedge clk);
      chk(bad == 0, "R6 sclk_o low in slave", 32'(bad), 32'd0);
      chk(frm_o == 1'b1, "R6 slave frame ended", 32'(frm_o), 32'd1);
      chk(cap == (txw & lmask(len)), "R6 slave tx bits", cap, txw & lmask(len));
      pop(got, v);
      chk(v && got == (rxw & lmask(len)), "R6 slave rx word", got, rxw & lmask(len));
      wr_ctl(5'(len - 1), 2'b00, 1'b1, 1'b0, 4096);
   endtask

   task automatic stays_idle(input string tag, input int n);
      int bad = 0;
      repeat (n) begin @(negedge clk); if (frm_o !== 1'b1 || sclk_o) bad++; end
      chk(bad == 0, tag, 32'(bad), 32'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] d; logic v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      rd(1'b1, d); chk(d == 32'h1, "R10 reset status", d, 32'h1);
      rd(1'b0, d); chk(d == 32'h0, "R1 reset control", d, 32'h0);
      chk(frm_o == 1'b1 && txd == 1'b0 && sclk_o == 1'b0, "R4 reset pins",
          {29'd0, frm_o, txd, sclk_o}, 32'h4);

      // control readback
      wr_ctl(5'd21, 2'b01, 1'b1, 1'b0, 300);
      rd(1'b0, d); chk(d == ctl(5'd21, 2'b01, 1'b1, 1'b0, 300), "R1 control readback",
                       d, ctl(5'd21, 2'b01, 1'b1, 1'b0, 300));

      // length sweeps
      for (int len = 4; len <= 32; len++)
         mframe(2'b00, len, 1, 32'hA5C3_96E1 ^ 32'(len * 32'h0101_0101), 32'h3C5A_F00F + 32'(len));
      for (int len = 4; len <= 32; len++)
         mframe(2'b01, len, 3, 32'h5A3C_0FF1 + 32'(len * 7), 32'hC3A5_1E69 ^ 32'(len));
      // ratio sweep
      for (int r = 1; r <= 8; r++) begin
         mframe(2'b00, 8, r, 32'hFFFF_FF00 | 32'(r * 37), 32'(8'h81 ^ r));
         mframe(2'b01, 8, r, 32'(8'hB4 + r), 32'(8'h4B - r));
      end
      mframe(2'b00, 4, 4096, 32'h9, 32'h6);

      // slave mode
      sframe(8, 32'hD2, 32'h1B);
      sframe(16, 32'h8001, 32'h7FFE);
      sframe(32, 32'hF0E1_D2C3, 32'h0F1E_2D3C);

      // reserved size and formats
      wr_ctl(5'd2, 2'b00, 1'b0, 1'b0, 1);
      push(32'h7);
      wr_ctl(5'd2, 2'b00, 1'b0, 1'b1, 1);
      stays_idle("R7 size code 2 idle", 100);
      rd(1'b1, d); chk(d == 32'h1, "R7 reserved size not busy", d, 32'h1);
      wr_ctl(5'd2, 2'b00, 1'b0, 1'b0, 1);
      for (int f = 2; f <= 3; f++) begin
         wr_ctl(5'd7, 2'(f), 1'b0, 1'b0, 1);
         push(32'h55);
         wr_ctl(5'd7, 2'(f), 1'b0, 1'b1, 1);
         stays_idle("R7 reserved format idle", 100);
         rd(1'b1, d); chk(d == 32'h1, "R7 reserved format not busy", d, 32'h1);
         wr_ctl(5'd7, 2'(f), 1'b0, 1'b0, 1);
      end

      // writes while enabled touch only enable
      wr_ctl(5'd7, 2'b00, 1'b0, 1'b1, 2);
      wr_ctl(5'd15, 2'b01, 1'b0, 1'b1, 10);
      rd(1'b0, d); chk(d == ctl(5'd7, 2'b00, 1'b0, 1'b1, 2), "R8 fields held", d,
                       ctl(5'd7, 2'b00, 1'b0, 1'b1, 2));
      push(32'h6C);
      observe(2'b00, 8, 2, 32'h6C, 32'h93);
      wr_ctl(5'd7, 2'b00, 1'b0, 1'b0, 2);

      // abort in the middle of a frame
      wr_ctl(5'd31, 2'b00, 1'b0, 1'b0, 4);
      for (int i = 0; i < 4; i++) push(32'h1234_0000 + 32'(i));
      chk(tx_ready == 1'b0, "R10 tx full", 32'(tx_ready), 32'd0);
      rd(1'b1, d); chk(d == 32'h0, "R10 status full", d, 32'h0);
      rxd_b = 1'b1;
      wr_ctl(5'd31, 2'b00, 1'b0, 1'b1, 4);
      begin
         int t = 0;
         while (!rx_valid && t < 400) begin @(negedge clk); t++; end
      end
      repeat (40) @(negedge clk);
      rd(1'b1, d); chk(d == 32'h7, "R10 busy with rx pending", d, 32'h7);
      wr_ctl(5'd5, 2'b01, 1'b1, 1'b0, 77);
      chk(frm_o == 1'b1, "R9 frame line released", 32'(frm_o), 32'd1);
      chk(rx_valid == 1'b0, "R9 rx flushed", 32'(rx_valid), 32'd0);
      rd(1'b1, d); chk(d == 32'h1, "R9 status cleared", d, 32'h1);
      rd(1'b0, d); chk(d == ctl(5'd31, 2'b00, 1'b0, 1'b0, 4), "R9 config kept", d,
                       ctl(5'd31, 2'b00, 1'b0, 1'b0, 4));
      wr_ctl(5'd31, 2'b00, 1'b0, 1'b1, 4);
      stays_idle("R9 tx flushed", 200);
      wr_ctl(5'd31, 2'b00, 1'b0, 1'b0, 4);

      // overrun
      wr_ctl(5'd3, 2'b00, 1'b0, 1'b0, 1);
      for (int i = 0; i < 4; i++) push(32'(i));
      wr_ctl(5'd3, 2'b00, 1'b0, 1'b1, 1);
      repeat (40) @(negedge clk);
      rd(1'b1, d); chk(d == 32'h3, "R10 four words received", d, 32'h3);
      push(32'hA);
      repeat (20) @(negedge clk);
      rd(1'b1, d); chk(d == 32'hB, "R11 overrun set", d, 32'hB);
      for (int i = 0; i < 4; i++) begin
         pop(d, v);
         chk(v && d == 32'hF, "R11 kept words", d, 32'hF);
      end
      rd(1'b1, d); chk(d == 32'h9, "R11 overrun sticky", d, 32'h9);
      wr_ctl(5'd3, 2'b00, 1'b0, 1'b0, 1);
      rd(1'b1, d); chk(d == 32'h1, "R11 overrun cleared by disable", d, 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule